// File: doc/BRIEF.md
# Incremental Chip-Phase Adjuster

This block derives the chip-clock enable of a spreading-code generator from a reference clock that runs a fixed integer number of times (`RATIO`, between 4 and 16) faster than the chip rate. In steady state it divides by `RATIO`. On request it runs one chip period that is one reference cycle shorter or one cycle longer. This moves the local code phase earlier or later by exactly one reference-clock period.

Requests are rate limited. A request is held until the next code-epoch strobe, and it takes effect on the first chip period that begins after that strobe. Only one request can be held at a time, so the code phase moves by at most one step per epoch. A sliding search can therefore sit on each code phase for a full epoch before it steps. A tracking loop can nudge the phase without overshooting.

A build-time mode restricts the block to advances only or to retards only, which suits a one-directional sweep. Each applied adjustment is confirmed by a single-cycle pulse. A request that arrives while another is still held is thrown away, and a sticky flag records the loss.

Top module: `chip_phase_slewer`

## Requirements
- R1: With no adjustment, `chip_en` pulses once every `RATIO` reference cycles. `chip_phase` counts up from 0 by one each cycle, and it returns to 0 in the cycle after `chip_en`.
- R2: An accepted advance request (`adv_req`) produces exactly one chip period of `RATIO-1` cycles. All other chip periods stay at `RATIO`.
- R3: An accepted retard request (`ret_req`) produces exactly one chip period of `RATIO+1` cycles. All other chip periods stay at `RATIO`.
- R4: A held request is applied only after an `epoch_stb` pulse in a later cycle than the request. A strobe in the same cycle as the request does not count. The adjusted period is the first chip period that begins after that strobe. Without a further strobe, a new request is never applied.
- R5: When `adv_req` and `ret_req` are high in the same cycle after mode masking, no request is formed. No adjustment follows, and `req_dropped` does not change.
- R6: A request that arrives while another request is held is discarded. `req_dropped` goes to 1 and stays at 1 until reset. The held request is still applied as before.
- R7: `adj_done` is high for exactly one cycle for each applied adjustment. That cycle is the first cycle of the adjusted period, where `chip_phase` is 0. `adj_done` is never high otherwise.
- R8: Parameter `MODE` selects the allowed directions: 0 allows both, 1 allows advance only, 2 allows retard only. A request in a disallowed direction is masked before R5 applies. A masked request has no effect on the chip periods.
- R9: While `rst_n` is low, `chip_phase` is 0 and `chip_en`, `adj_done` and `req_dropped` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, `RATIO` times the chip rate |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_req | input | 1 | Request to shorten one chip period by one cycle |
| ret_req | input | 1 | Request to lengthen one chip period by one cycle |
| epoch_stb | input | 1 | One-cycle code-epoch strobe |
| chip_en | output | 1 | One-cycle enable at the last cycle of each chip period |
| chip_phase | output | PW | Reference-cycle position inside the current chip period |
| adj_done | output | 1 | One-cycle confirmation of an applied adjustment |
| req_dropped | output | 1 | Sticky: a request was lost because one was already held |

## Verification
Two events can land on the same reference cycle: a new request arriving and an epoch strobe. The same is true of an armed adjustment and a chip boundary meeting a second incoming request. The bench raises `adv_req` together with `epoch_stb` and expects no adjustment until a later strobe. It also sends a retard while an advance is still held, and expects `req_dropped` to be set while only the single shortened period appears. Both cases are judged from the histogram of measured chip-period lengths and from the count of `adj_done` pulses.

// File: rtl/chip_slew_pkg.sv
package chip_slew_pkg;

  typedef enum logic {
    DIR_ADV = 1'b0,
    DIR_RET = 1'b1
  } slew_dir_e;

  localparam int unsigned MODE_BOTH     = 0;
  localparam int unsigned MODE_ADV_ONLY = 1;
  localparam int unsigned MODE_RET_ONLY = 2;

  // length in reference cycles of a chip period
  function automatic int unsigned period_len(input int unsigned ratio,
                                             input logic adjust,
                                             input slew_dir_e dir);
    if (!adjust)
      return ratio;
    else if (dir == DIR_RET)
      return ratio + 1;
    else
      return ratio - 1;
  endfunction

endpackage

// File: rtl/slew_req_mask.sv
module slew_req_mask
  import chip_slew_pkg::*;
#(
  parameter int unsigned MODE = MODE_BOTH
) (
  input  logic      adv_req,
  input  logic      ret_req,
  output logic      req_valid,
  output slew_dir_e req_dir
);
  logic adv_ok;
  logic ret_ok;

  generate
    if (MODE == MODE_ADV_ONLY) begin : g_adv_only
      assign adv_ok = adv_req;
      assign ret_ok = 1'b0;
    end else if (MODE == MODE_RET_ONLY) begin : g_ret_only
      assign adv_ok = 1'b0;
      assign ret_ok = ret_req;
    end else begin : g_both
      assign adv_ok = adv_req;
      assign ret_ok = ret_req;
    end
  endgenerate

  // opposite requests in one cycle cancel
  assign req_valid = adv_ok ^ ret_ok;
  assign req_dir   = ret_ok ? DIR_RET : DIR_ADV;
endmodule

// File: rtl/slew_req_ctrl.sv
module slew_req_ctrl
  import chip_slew_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  slew_dir_e req_dir,
  input  logic      epoch_stb,
  input  logic      boundary,
  output logic      apply,
  output slew_dir_e apply_dir,
  output logic      held,
  output logic      dropped
);
  logic      pend_q;
  logic      arm_q;
  slew_dir_e dir_q;
  logic      drop_q;
  logic      accept;
  logic      reject;
  logic      applied_in_epoch_q;

  assign accept    = req_valid & ~pend_q;
  assign reject    = req_valid & pend_q;
  assign apply     = boundary & arm_q;
  assign apply_dir = dir_q;
  assign held      = pend_q;
  assign dropped   = drop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      arm_q  <= 1'b0;
      dir_q  <= DIR_ADV;
      drop_q <= 1'b0;
    end else begin
      if (apply) begin
        pend_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (epoch_stb && pend_q) begin
        arm_q <= 1'b1;
      end
      if (accept) begin
        pend_q <= 1'b1;
        arm_q  <= 1'b0;
        dir_q  <= req_dir;
      end
      if (reject) drop_q <= 1'b1;
    end
  end

  // checker state: has an adjustment been applied since the last strobe
  always_ff @(posedge clk) begin
    if (!rst_n) applied_in_epoch_q <= 1'b0;
    else if (epoch_stb) applied_in_epoch_q <= 1'b0;
    else if (apply) applied_in_epoch_q <= 1'b1;
  end

  p_one_per_epoch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> !applied_in_epoch_q);

  p_arm_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |-> $past(epoch_stb));

  p_drop_keeps_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !apply) |=> (pend_q && $stable(dir_q)));
endmodule

// File: rtl/chip_divider.sv
module chip_divider
  import chip_slew_pkg::*;
#(
  parameter int unsigned RATIO = 8,
  parameter int unsigned PW    = $clog2(RATIO + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  slew_dir_e     apply_dir,
  output logic          chip_en,
  output logic [PW-1:0] phase
);
  localparam logic [PW-1:0] NORM_LAST  = PW'(RATIO - 1);
  localparam logic [PW-1:0] SHORT_LAST = PW'(RATIO - 2);
  localparam logic [PW-1:0] LONG_LAST  = PW'(RATIO);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last_q;

  assign chip_en = (cnt_q == last_q);
  assign phase   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= NORM_LAST;
    end else if (chip_en) begin
      cnt_q  <= '0;
      last_q <= PW'(period_len(RATIO, apply, apply_dir) - 1);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chip_en |=> (cnt_q == '0));

  p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (last_q >= SHORT_LAST) && (last_q <= LONG_LAST));

  p_plain_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !apply) |=> (last_q == NORM_LAST));
endmodule

// File: rtl/chip_phase_slewer.sv
module chip_phase_slewer
  import chip_slew_pkg::*;
#(
  parameter int unsigned RATIO = 8,
  parameter int unsigned MODE  = MODE_BOTH,
  parameter int unsigned PW    = $clog2(RATIO + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_req,
  input  logic          ret_req,
  input  logic          epoch_stb,
  output logic          chip_en,
  output logic [PW-1:0] chip_phase,
  output logic          adj_done,
  output logic          req_dropped
);
  logic      req_valid;
  slew_dir_e req_dir;
  logic      apply;
  slew_dir_e apply_dir;
  logic      held;
  logic      adj_done_q;

  slew_req_mask #(.MODE(MODE)) u_mask (
    .adv_req  (adv_req),
    .ret_req  (ret_req),
    .req_valid(req_valid),
    .req_dir  (req_dir)
  );

  slew_req_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_dir  (req_dir),
    .epoch_stb(epoch_stb),
    .boundary (chip_en),
    .apply    (apply),
    .apply_dir(apply_dir),
    .held     (held),
    .dropped  (req_dropped)
  );

  chip_divider #(.RATIO(RATIO), .PW(PW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .apply    (apply),
    .apply_dir(apply_dir),
    .chip_en  (chip_en),
    .phase    (chip_phase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) adj_done_q <= 1'b0;
    else        adj_done_q <= apply;
  end
  assign adj_done = adj_done_q;

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adj_done |=> !adj_done);

  p_done_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adj_done |-> (chip_phase == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_dropped |=> req_dropped);

  p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_BOTH && adv_req && ret_req && !held) |=> (!held && $stable(req_dropped)));

  p_mode_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_ADV_ONLY && apply) |-> (apply_dir == DIR_ADV));

  p_mode_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == MODE_RET_ONLY && apply) |-> (apply_dir == DIR_RET));
endmodule

// File: tb/test_chip_phase_slewer.sv
module test_chip_phase_slewer;
  localparam int unsigned M  = 8;
  localparam int unsigned PW = $clog2(M + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adv_req = 1'b0, ret_req = 1'b0, epoch_stb = 1'b0;
  logic [1:0] en, done, drp;
  logic [PW-1:0] ph0, ph1;

  int checks = 0, failures = 0;
  bit finished = 0;

  int gap[2], n_short[2], n_norm[2], n_long[2], n_bad[2], n_done[2], ph_err[2];
  bit seen[2], prev_en[2];
  logic [PW-1:0] prev_ph[2];

  always #2.5 clk = ~clk;

  chip_phase_slewer #(.RATIO(M), .MODE(0)) i_chip_phase_slewer (
    .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .ret_req(ret_req),
    .epoch_stb(epoch_stb), .chip_en(en[0]), .chip_phase(ph0),
    .adj_done(done[0]), .req_dropped(drp[0]));

  chip_phase_slewer #(.RATIO(M), .MODE(1)) i_chip_phase_slewer_adv (
    .clk(clk), .rst_n(rst_n), .adv_req(adv_req), .ret_req(ret_req),
    .epoch_stb(epoch_stb), .chip_en(en[1]), .chip_phase(ph1),
    .adj_done(done[1]), .req_dropped(drp[1]));

  // period monitor, sampled on the falling edge
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      logic [PW-1:0] p;
      p = (i == 0) ? ph0 : ph1;
      if (!rst_n) begin
        gap[i] = 0; seen[i] = 0; prev_en[i] = 0; prev_ph[i] = '0;
      end else begin
        if (seen[i] || prev_en[i]) begin
          if (prev_en[i] && p != 0) ph_err[i]++;
          if (!prev_en[i] && p != prev_ph[i] + 1'b1) ph_err[i]++;
        end
        gap[i]++;
        if (en[i]) begin
          if (seen[i]) begin
            if (gap[i] == M - 1)      n_short[i]++;
            else if (gap[i] == M)     n_norm[i]++;
            else if (gap[i] == M + 1) n_long[i]++;
            else                      n_bad[i]++;
          end
          seen[i] = 1; gap[i] = 0;
        end
        if (done[i]) begin
          n_done[i]++;
          if (p != 0) ph_err[i]++;
        end
        prev_en[i] = en[i]; prev_ph[i] = p;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_stats();
    tick(1);
    for (int i = 0; i < 2; i++) begin
      n_short[i] = 0; n_norm[i] = 0; n_long[i] = 0; n_bad[i] = 0;
      n_done[i] = 0; ph_err[i] = 0;
    end
  endtask

  task automatic pulse(input bit a, input bit r, input bit e);
    tick(1);
    adv_req = a; ret_req = r; epoch_stb = e;
    tick(1);
    adv_req = 0; ret_req = 0; epoch_stb = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(4);
    @(negedge clk);
    chk_eq("R9 chip_phase", int'(ph0), 0);
    chk_eq("R9 chip_en", int'(en[0]), 0);
    chk_eq("R9 adj_done", int'(done[0]), 0);
    chk_eq("R9 req_dropped", int'(drp[0]), 0);
    tick(1);
    rst_n = 1;
  endtask

  task automatic t_nominal();
    clear_stats();
    tick(90);
    chk(n_norm[0] >= 9, "R1 nominal periods", n_norm[0], 9);
    chk_eq("R1 no short", n_short[0], 0);
    chk_eq("R1 no long", n_long[0] + n_bad[0], 0);
    chk_eq("R1 phase sequence", ph_err[0], 0);
  endtask

  task automatic t_cancel();
    clear_stats();
    pulse(1, 1, 0);
    tick(5);
    pulse(0, 0, 1);
    tick(40);
    chk_eq("R5 no adjust", n_short[0] + n_long[0], 0);
    chk_eq("R5 no adj_done", n_done[0], 0);
    chk_eq("R5 not dropped", int'(drp[0]), 0);
  endtask

  task automatic t_advance();
    clear_stats();
    pulse(1, 0, 0);
    tick(20);
    pulse(0, 0, 1);
    tick(40);
    chk_eq("R2 one short period", n_short[0], 1);
    chk_eq("R2 no long/bad", n_long[0] + n_bad[0], 0);
    chk_eq("R7 one adj_done", n_done[0], 1);
    chk_eq("R7 adj_done at phase 0", ph_err[0], 0);
  endtask

  task automatic t_retard();
    clear_stats();
    pulse(0, 1, 0);
    tick(13);
    pulse(0, 0, 1);
    tick(40);
    chk_eq("R3 one long period", n_long[0], 1);
    chk_eq("R3 no short/bad", n_short[0] + n_bad[0], 0);
    chk_eq("R7 one adj_done", n_done[0], 1);
  endtask

  task automatic t_hold();
    clear_stats();
    pulse(1, 0, 0);
    tick(50);
    chk_eq("R4 held without strobe", n_short[0], 0);
    chk_eq("R4 no adj_done yet", n_done[0], 0);
    pulse(0, 0, 1);
    tick(30);
    chk_eq("R4 applied after strobe", n_short[0], 1);
    pulse(1, 0, 0);
    tick(40);
    chk_eq("R4 second waits for strobe", n_short[0], 1);
    pulse(0, 0, 1);
    tick(30);
    chk_eq("R4 second applied", n_short[0], 2);
    pulse(1, 0, 1);
    tick(40);
    chk_eq("R4 same-cycle strobe ignored", n_short[0], 2);
    pulse(0, 0, 1);
    tick(30);
    chk_eq("R4 later strobe applies", n_short[0], 3);
    chk_eq("R7 adj_done count", n_done[0], 3);
    chk_eq("R4 no bad periods", n_long[0] + n_bad[0], 0);
  endtask

  task automatic t_drop();
    clear_stats();
    chk_eq("R6 flag clear before", int'(drp[0]), 0);
    pulse(1, 0, 0);
    tick(3);
    pulse(0, 1, 0);
    @(negedge clk);
    chk_eq("R6 flag set", int'(drp[0]), 1);
    tick(1);
    pulse(0, 0, 1);
    tick(40);
    chk_eq("R6 held advance applied", n_short[0], 1);
    chk_eq("R6 dropped retard not applied", n_long[0], 0);
    chk_eq("R6 flag sticky", int'(drp[0]), 1);
  endtask

  task automatic t_mode();
    clear_stats();
    pulse(0, 1, 0);
    tick(5);
    pulse(0, 0, 1);
    tick(40);
    chk_eq("R8 retard masked in advance-only", n_long[1] + n_short[1], 0);
    chk_eq("R8 both-mode retard applied", n_long[0], 1);
    pulse(1, 0, 0);
    tick(5);
    pulse(0, 0, 1);
    tick(40);
    chk_eq("R8 advance allowed", n_short[1], 1);
    pulse(1, 1, 0);
    tick(5);
    pulse(0, 0, 1);
    tick(40);
    chk_eq("R8 mask before cancel", n_short[1], 2);
    chk_eq("R5 cancel in both-mode", n_short[0], 1);
    chk_eq("R8 adj_done count", n_done[1], 2);
  endtask

  initial begin
    do_reset();
    t_nominal();
    t_cancel();
    t_advance();
    t_retard();
    t_hold();
    t_drop();
    do_reset();
    t_mode();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule